// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer Controller

This block sits between a packet-receiving serial engine and a CPU. It governs the receive region of one bulk or interrupt OUT endpoint inside a shared packet RAM. The RAM is outside the block and is reached through a byte write port and a two-byte read port. Configuration inputs place the region, set its size and select the mode. Single-buffer mode holds one packet. Double-buffer mode holds two packets in two equal halves that are filled and drained alternately.

The receive engine streams bytes, then marks the end of a good packet or drops a bad one. When no half is free, the block refuses the packet: it writes nothing, pulses a NAK indication and leaves its state alone. A two-bit occupancy flag pair tells the CPU what is waiting. The CPU reads through a data port with a self-advancing pointer, either one byte or one 16-bit word per read. It writes a clear strobe once it has unloaded a half. The length of the packet being unloaded is also shown.

Continuous mode applies to bulk endpoints only. In this mode several packets are gathered into one data set. The set is handed to the CPU only when the half is full or a short packet ends it.

Top module: `usb_out_ep_buffer`

## Requirements
- R1: After reset the flags read 00, `sie_ready` is 1, `buf_len` is 0 and `cpu_rd_data` is 0.
- R2: Each half spans `cfg_size`×64 bytes, where a field value of 0 means 1024 bytes. Half 0 starts at `cfg_start`×64. Half 1 follows immediately after half 0. Received bytes are written to consecutive addresses, and addresses wrap modulo the RAM size.
- R3: In single mode an accepted packet moves the flags from 00 to 11. A clear moves them from 11 to 00.
- R4: In double mode packets move the flags 00→10→11 and clears move them 11→10→00. The halves are filled and drained alternately, starting with half 0.
- R5: While no half is free, `sie_ready` is 0. A packet arriving then is refused: `sie_nak` is 1 during its end cycle, no byte is written and the flags are unchanged.
- R6: A clear while the flags are 00 has no effect. The flags stay 00 and the fill order of the halves is not disturbed.
- R7: `cpu_rd_data` shows the bytes at the read pointer, low byte at the lower address. A byte read returns the byte zero-extended. A word read advances the pointer by 2 and a byte read advances it by 1. After a clear the pointer moves to the start of the next unread half.
- R8: While the upper flag is 0, `cpu_rd_data` is 0 and reads do not move the pointer.
- R9: `buf_len` shows the stored byte count of the half being unloaded.
- R10: In continuous mode a data set completes only when its byte total reaches the half size or a packet shorter than `cfg_maxp` ends it. Earlier packets change no flag and `buf_len` reports the set total.
- R11: Continuous mode takes effect only when `cfg_bulk` is 1. Otherwise every packet completes on its own.
- R12: A dropped packet changes no flag. The next packet is written from the same offset.
- R13: Bytes beyond the half size are not written, and the stored length saturates at the half size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_start | input | 5 | Region start in 64-byte units |
| cfg_size | input | 4 | Half size in 64-byte units, 0 = 1024 bytes |
| cfg_double | input | 1 | Double-buffer mode |
| cfg_cont | input | 1 | Continuous (multi-packet data set) mode |
| cfg_bulk | input | 1 | Endpoint is bulk |
| cfg_maxp | input | 11 | Maximum packet size |
| sie_byte_vld | input | 1 | Received byte valid |
| sie_byte | input | 8 | Received byte |
| sie_pkt_end | input | 1 | Good packet ended (cycle after last byte) |
| sie_pkt_drop | input | 1 | Bad packet, discard its bytes |
| sie_ready | output | 1 | Current or next packet will be accepted |
| sie_nak | output | 1 | Packet refused, valid with `sie_pkt_end` |
| cpu_rd | input | 1 | Read strobe, advances the pointer |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_rd_data | output | 16 | Data at the read pointer |
| cpu_clr | input | 1 | Buffer-unloaded strobe |
| buf_flags | output | 2 | Occupancy flags |
| buf_len | output | 11 | Byte count of the half being unloaded |
| ram_we | output | 1 | RAM byte write enable |
| ram_waddr | output | 11 | RAM write address |
| ram_wdata | output | 8 | RAM write byte |
| ram_raddr | output | 11 | RAM read address |
| ram_rdata | input | 16 | RAM bytes at raddr+1 (high) and raddr (low) |

## Verification
A single short packet in single mode separates the one-packet 00/11 rule from the double-mode 10 step. Back-to-back packets in double mode, with the second half wrapping past the top of RAM, show whether the halves alternate and whether addresses wrap correctly. An oversized packet, a dropped packet and an extra packet sent while both halves are full probe the length cap, the rewind of the write offset and the refusal path. In continuous mode, two full-size packets and a full-plus-short pair separate the two completion rules, and a non-bulk run shows that the mode is gated.

// File: rtl/eob_pkg.sv
package eob_pkg;

  typedef enum logic [1:0] {
    FL_EMPTY = 2'b00,
    FL_ONE   = 2'b10,
    FL_FULL  = 2'b11
  } occ_flags_e;

  // flags seen by the CPU for a given number of held packets
  function automatic logic [1:0] flags_of(input logic [1:0] held, input logic dbl);
    if (held == 2'd0)      return FL_EMPTY;
    else if (held == 2'd1) return dbl ? FL_ONE : FL_FULL;
    else                   return FL_FULL;
  endfunction

  function automatic logic room_left(input logic [1:0] held, input logic dbl);
    return dbl ? (held != 2'd2) : (held == 2'd0);
  endfunction

endpackage

// File: rtl/eob_region.sv
module eob_region #(
  parameter int ADDR_W    = 11,
  parameter int SIZE_W    = 4,
  parameter int UNIT_LOG2 = 6,
  parameter int START_W   = ADDR_W - UNIT_LOG2,
  parameter int LEN_W     = SIZE_W + UNIT_LOG2 + 1
) (
  input  logic [START_W-1:0] start_units,
  input  logic [SIZE_W-1:0]  size_units,
  output logic [LEN_W-1:0]   half_bytes,
  output logic [ADDR_W-1:0]  base0,
  output logic [ADDR_W-1:0]  base1
);

  function automatic logic [LEN_W-1:0] span(input logic [SIZE_W-1:0] f);
    logic [LEN_W-1:0] units;
    units = (f == '0) ? LEN_W'(1 << SIZE_W) : LEN_W'(f);
    return units << UNIT_LOG2;
  endfunction

  function automatic logic [ADDR_W-1:0] origin(input logic [START_W-1:0] s);
    return ADDR_W'(s) << UNIT_LOG2;
  endfunction

  assign half_bytes = span(size_units);
  assign base0      = origin(start_units);
  assign base1      = base0 + ADDR_W'(half_bytes);

endmodule

// File: rtl/eob_sie_side.sv
module eob_sie_side #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 11,
  parameter int MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_eff,
  input  logic [MAXP_W-1:0] maxp,
  input  logic [LEN_W-1:0]  half_bytes,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              free,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              pkt_end,
  input  logic              pkt_drop,
  output logic              ready,
  output logic              nak,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_pkt;
  logic             acc;
  logic [LEN_W-1:0] set_off;
  logic [CNT_W-1:0] pkt_bytes;
  logic [CNT_W-1:0] total;
  logic             accept_eff;
  logic             under_cap;
  logic             short_pkt;
  logic             set_done;

  function automatic logic [CNT_W-1:0] set_total(input logic [LEN_W-1:0] off,
                                                 input logic [CNT_W-1:0] n);
    return CNT_W'(off) + n;
  endfunction

  assign accept_eff = in_pkt ? acc : free;
  assign total      = set_total(set_off, pkt_bytes);
  assign under_cap  = total < CNT_W'(half_bytes);
  assign short_pkt  = pkt_bytes < CNT_W'(maxp);
  assign set_done   = !cont_eff || !under_cap || short_pkt;

  assign ready      = accept_eff;
  assign nak        = pkt_end && !accept_eff;
  assign commit     = pkt_end && accept_eff && set_done;
  assign commit_len = under_cap ? total[LEN_W-1:0] : half_bytes;

  assign ram_we     = byte_vld && accept_eff && under_cap;
  assign ram_waddr  = wr_base + ADDR_W'(total);
  assign ram_wdata  = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      acc       <= 1'b0;
      set_off   <= '0;
      pkt_bytes <= '0;
    end else if (pkt_end || pkt_drop) begin
      in_pkt    <= 1'b0;
      pkt_bytes <= '0;
      if (commit)
        set_off <= '0;
      else if (pkt_end && accept_eff)
        set_off <= total[LEN_W-1:0];
    end else if (byte_vld) begin
      in_pkt <= 1'b1;
      if (!in_pkt) acc <= free;
      if (accept_eff && pkt_bytes != CNT_MAX)
        pkt_bytes <= pkt_bytes + CNT_W'(1);
    end
  end

  a_r12_drop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop && !pkt_end |=> pkt_bytes == '0 && set_off == $past(set_off));

  a_r13_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> total < CNT_W'(half_bytes));

endmodule

// File: rtl/eob_occupancy.sv
module eob_occupancy
  import eob_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             clr,
  output logic             free,
  output logic [1:0]       flags,
  output logic             wr_sel,
  output logic             rd_sel,
  output logic             rd_ok,
  output logic             clr_ok,
  output logic [LEN_W-1:0] rd_len
);

  localparam int HALVES = 2;

  logic [1:0]       held;
  logic             wr_h;
  logic             rd_h;
  logic [LEN_W-1:0] held_len [HALVES];

  assign free   = room_left(held, dbl);
  assign flags  = flags_of(held, dbl);
  assign rd_ok  = flags[1];
  assign clr_ok = clr && (held != 2'd0);
  assign wr_sel = dbl & wr_h;
  assign rd_sel = dbl & rd_h;
  assign rd_len = rd_ok ? held_len[rd_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 2'd0;
      wr_h <= 1'b0;
      rd_h <= 1'b0;
    end else begin
      unique case ({commit, clr_ok})
        2'b10:   held <= held + 2'd1;
        2'b01:   held <= held - 2'd1;
        default: held <= held;
      endcase
      if (commit && dbl) wr_h <= ~wr_h;
      if (clr_ok && dbl) rd_h <= ~rd_h;
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        held_len[h] <= '0;
      else if (commit && wr_sel == 1'(h))
        held_len[h] <= commit_len;
    end
  end

  a_r5_commit_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> free);

  a_r3_single_depth: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> held <= 2'd1);

  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && flags == 2'b00 && !commit |=> flags == 2'b00);

  a_r4_second_packet: assert property (@(posedge clk) disable iff (!rst_n)
    dbl && $stable(dbl) && commit && !clr_ok && flags == 2'b10 |=> flags == 2'b11);

endmodule

// File: rtl/eob_cpu_port.sv
module eob_cpu_port #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ok,
  input  logic              clr_ok,
  input  logic              cpu_rd,
  input  logic              cpu_word,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [15:0]       ram_rdata,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic [15:0]       cpu_rd_data
);

  logic [LEN_W-1:0] rd_off;

  function automatic logic [LEN_W-1:0] stride(input logic word);
    return word ? LEN_W'(2) : LEN_W'(1);
  endfunction

  assign ram_raddr = rd_base + ADDR_W'(rd_off);

  always_comb begin
    if (!rd_ok)        cpu_rd_data = '0;
    else if (cpu_word) cpu_rd_data = ram_rdata;
    else               cpu_rd_data = {8'h00, ram_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_off <= '0;
    else if (clr_ok)
      rd_off <= '0;
    else if (cpu_rd && rd_ok)
      rd_off <= rd_off + stride(cpu_word);
  end

  a_r8_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok && !clr_ok |=> $stable(rd_off));

  a_r7_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && rd_ok && !clr_ok |=>
      rd_off == $past(rd_off) + ($past(cpu_word) ? LEN_W'(2) : LEN_W'(1)));

  a_r7_clear_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> rd_off == '0);

endmodule

// File: rtl/usb_out_ep_buffer.sv
module usb_out_ep_buffer #(
  parameter int ADDR_W    = 11,
  parameter int SIZE_W    = 4,
  parameter int UNIT_LOG2 = 6,
  parameter int MAXP_W    = 11,
  localparam int START_W  = ADDR_W - UNIT_LOG2,
  localparam int LEN_W    = SIZE_W + UNIT_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [START_W-1:0] cfg_start,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic               cfg_double,
  input  logic               cfg_cont,
  input  logic               cfg_bulk,
  input  logic [MAXP_W-1:0]  cfg_maxp,
  input  logic               sie_byte_vld,
  input  logic [7:0]         sie_byte,
  input  logic               sie_pkt_end,
  input  logic               sie_pkt_drop,
  output logic               sie_ready,
  output logic               sie_nak,
  input  logic               cpu_rd,
  input  logic               cpu_word,
  output logic [15:0]        cpu_rd_data,
  input  logic               cpu_clr,
  output logic [1:0]         buf_flags,
  output logic [LEN_W-1:0]   buf_len,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_waddr,
  output logic [7:0]         ram_wdata,
  output logic [ADDR_W-1:0]  ram_raddr,
  input  logic [15:0]        ram_rdata
);

  logic [LEN_W-1:0]  half_bytes;
  logic [ADDR_W-1:0] base0, base1;
  logic              free, commit, clr_ok, rd_ok;
  logic              wr_sel, rd_sel;
  logic [LEN_W-1:0]  commit_len;
  logic              cont_eff;

  assign cont_eff = cfg_cont && cfg_bulk;

  eob_region #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNIT_LOG2(UNIT_LOG2),
    .START_W(START_W), .LEN_W(LEN_W)
  ) u_region (
    .start_units(cfg_start), .size_units(cfg_size),
    .half_bytes(half_bytes), .base0(base0), .base1(base1)
  );

  eob_sie_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAXP_W(MAXP_W)) u_sie (
    .clk(clk), .rst_n(rst_n), .cont_eff(cont_eff), .maxp(cfg_maxp),
    .half_bytes(half_bytes), .wr_base(wr_sel ? base1 : base0), .free(free),
    .byte_vld(sie_byte_vld), .byte_in(sie_byte), .pkt_end(sie_pkt_end),
    .pkt_drop(sie_pkt_drop), .ready(sie_ready), .nak(sie_nak),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .commit(commit), .commit_len(commit_len)
  );

  eob_occupancy #(.LEN_W(LEN_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .dbl(cfg_double), .commit(commit),
    .commit_len(commit_len), .clr(cpu_clr), .free(free), .flags(buf_flags),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_ok(rd_ok), .clr_ok(clr_ok),
    .rd_len(buf_len)
  );

  eob_cpu_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .rd_ok(rd_ok), .clr_ok(clr_ok),
    .cpu_rd(cpu_rd), .cpu_word(cpu_word), .rd_base(rd_sel ? base1 : base0),
    .ram_rdata(ram_rdata), .ram_raddr(ram_raddr), .cpu_rd_data(cpu_rd_data)
  );

  a_r5_refused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sie_nak |-> !commit);

endmodule

// File: tb/usb_out_ep_buffer_test.sv
module usb_out_ep_buffer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_start = 5'd2;
  logic [3:0]  cfg_size = 4'd1;
  logic        cfg_double = 1'b0, cfg_cont = 1'b0, cfg_bulk = 1'b1;
  logic [10:0] cfg_maxp = 11'd64;
  logic        sie_byte_vld = 1'b0, sie_pkt_end = 1'b0, sie_pkt_drop = 1'b0;
  logic [7:0]  sie_byte = 8'h00;
  logic        sie_ready, sie_nak;
  logic        cpu_rd = 1'b0, cpu_word = 1'b0, cpu_clr = 1'b0;
  logic [15:0] cpu_rd_data;
  logic [1:0]  buf_flags;
  logic [10:0] buf_len;
  logic        ram_we;
  logic [10:0] ram_waddr, ram_raddr;
  logic [7:0]  ram_wdata;
  logic [15:0] ram_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  usb_out_ep_buffer uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_size(cfg_size),
    .cfg_double(cfg_double), .cfg_cont(cfg_cont), .cfg_bulk(cfg_bulk),
    .cfg_maxp(cfg_maxp), .sie_byte_vld(sie_byte_vld), .sie_byte(sie_byte),
    .sie_pkt_end(sie_pkt_end), .sie_pkt_drop(sie_pkt_drop),
    .sie_ready(sie_ready), .sie_nak(sie_nak), .cpu_rd(cpu_rd),
    .cpu_word(cpu_word), .cpu_rd_data(cpu_rd_data), .cpu_clr(cpu_clr),
    .buf_flags(buf_flags), .buf_len(buf_len), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata)
  );

  // packet RAM model
  logic [7:0] mem [2048];
  initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
  always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;
  assign ram_rdata = {mem[ram_raddr + 11'd1], mem[ram_raddr]};

  typedef struct { int addr; int data; } wr_item_t;
  wr_item_t exp_q[$];

  function automatic int pat(int seed, int i);
    return (seed * 17 + i * 5 + 1) & 8'hFF;
  endfunction

  function automatic int wrap(int a);
    return a % 2048;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every RAM write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) check("R5/R13 unexpected write addr", int'(ram_waddr), -1);
      else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check("R2 write address", int'(ram_waddr), e.addr);
        check("R2 write data", int'(ram_wdata), e.data);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(int n, int seed, int base, int off, int cap, bit accept, bit drop);
    for (int i = 0; i < n; i++)
      if (accept && off + i < cap) exp_q.push_back('{wrap(base + off + i), pat(seed, i)});
    for (int i = 0; i < n; i++) begin
      step();
      sie_byte_vld = 1'b1;
      sie_byte = 8'(pat(seed, i));
    end
    step();
    sie_byte_vld = 1'b0;
    if (drop) sie_pkt_drop = 1'b1; else sie_pkt_end = 1'b1;
    @(negedge clk);
    if (!drop) check("R5 nak at packet end", int'(sie_nak), accept ? 0 : 1);
    step();
    sie_pkt_end = 1'b0;
    sie_pkt_drop = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpu_read(bit word, output int data);
    step();
    cpu_rd = 1'b1;
    cpu_word = word;
    @(negedge clk);
    data = int'(cpu_rd_data);
    step();
    cpu_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear();
    step();
    cpu_clr = 1'b1;
    step();
    cpu_clr = 1'b0;
    @(negedge clk);
  endtask

  function automatic int w16(int seed, int i);
    return (pat(seed, i + 1) << 8) | pat(seed, i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags", int'(buf_flags), 0);
    check("R1 ready", int'(sie_ready), 1);
    check("R1 len", int'(buf_len), 0);
    check("R1 data", int'(cpu_rd_data), 0);

    // single mode, base 128, 64-byte half
    clear();
    check("R6 clear on empty", int'(buf_flags), 0);
    send_pkt(10, 1, 128, 0, 64, 1, 0);
    check("R3 fill", int'(buf_flags), 3);
    check("R9 length", int'(buf_len), 10);
    check("R5 ready low when full", int'(sie_ready), 0);
    send_pkt(5, 2, 128, 0, 64, 0, 0);
    check("R5 flags kept", int'(buf_flags), 3);
    check("R5 length kept", int'(buf_len), 10);
    cpu_read(1, d); check("R7 first word", d, w16(1, 0));
    cpu_read(0, d); check("R7 byte zero-extended", d, pat(1, 2));
    cpu_read(1, d); check("R7 word after byte step", d, w16(1, 3));
    clear();
    check("R3 clear", int'(buf_flags), 0);
    check("R8 data zero when empty", int'(cpu_rd_data), 0);
    cpu_read(1, d); check("R8 gated read", d, 0);
    send_pkt(3, 3, 128, 0, 64, 1, 0);
    cpu_read(1, d); check("R8 pointer unmoved, R7 rewind", d, w16(3, 0));
    clear();

    // double mode, half0 at 1984, half1 wraps to 0
    cfg_double = 1'b1;
    cfg_start = 5'd31;
    send_pkt(4, 4, 1984, 0, 64, 1, 0);
    check("R4 first packet", int'(buf_flags), 2);
    send_pkt(6, 5, 2048, 0, 64, 1, 0);
    check("R4 second packet", int'(buf_flags), 3);
    check("R5 ready low double", int'(sie_ready), 0);
    send_pkt(3, 6, 0, 0, 64, 0, 0);
    check("R5 double flags kept", int'(buf_flags), 3);
    check("R9 first half length", int'(buf_len), 4);
    cpu_read(1, d); check("R7 half0 word", d, w16(4, 0));
    clear();
    check("R4 clear to one", int'(buf_flags), 2);
    check("R9 second half length", int'(buf_len), 6);
    check("R7 next half data", int'(cpu_rd_data), w16(5, 0));
    clear();
    check("R4 clear to empty", int'(buf_flags), 0);
    clear();
    check("R6 idle clear ignored", int'(buf_flags), 0);
    send_pkt(2, 7, 1984, 0, 64, 1, 0);
    check("R6 order kept", int'(buf_flags), 2);
    clear();

    // oversize packet into half1
    send_pkt(70, 8, 2048, 0, 64, 1, 0);
    check("R13 saturated length", int'(buf_len), 64);
    clear();

    // dropped packet into half0, then retry
    send_pkt(5, 9, 1984, 0, 64, 1, 1);
    check("R12 drop keeps flags", int'(buf_flags), 0);
    send_pkt(3, 10, 1984, 0, 64, 1, 0);
    check("R12 retry flags", int'(buf_flags), 2);
    check("R12 retry length", int'(buf_len), 3);
    cpu_read(1, d); check("R12 retry data at offset 0", d, w16(10, 0));
    clear();

    // continuous mode, single, base 256, 128-byte half
    cfg_double = 1'b0;
    cfg_cont = 1'b1;
    cfg_start = 5'd4;
    cfg_size = 4'd2;
    send_pkt(64, 11, 256, 0, 128, 1, 0);
    check("R10 partial set no status", int'(buf_flags), 0);
    check("R10 partial set still ready", int'(sie_ready), 1);
    send_pkt(64, 12, 256, 64, 128, 1, 0);
    check("R10 full set", int'(buf_flags), 3);
    check("R10 full length", int'(buf_len), 128);
    clear();
    send_pkt(64, 13, 256, 0, 128, 1, 0);
    check("R10 partial again", int'(buf_flags), 0);
    send_pkt(10, 14, 256, 64, 128, 1, 0);
    check("R10 short ends set", int'(buf_flags), 3);
    check("R10 short total length", int'(buf_len), 74);
    clear();

    // continuous requested on non-bulk endpoint
    cfg_bulk = 1'b0;
    send_pkt(64, 15, 256, 0, 128, 1, 0);
    check("R11 non-bulk completes per packet", int'(buf_flags), 3);
    check("R11 length", int'(buf_len), 64);
    clear();

    check("R2 all expected writes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule